// File: doc/BRIEF.md
# DDR2 Power-Up Initialization Sequencer

This block drives the power-up command sequence that a DDR2 memory needs before it can be used. On a start pulse it latches its configuration: the number of chip selects to set up, a base mode-register word, a base extended-mode-register word and a wait length. It then walks every chip select from 0 upward. For each chip it emits a fixed list of twelve commands, with four timed pauses between them. These are a NOP, two precharge-all commands, two auto-refresh commands and seven mode-register writes. The mode-register writes cover the second and third extended registers, the extended register (including entry to and exit from off-chip-driver calibration) and the main mode register (with and without the DLL-reset request).

Commands leave through a valid/ready port as one word: chip select, command kind, bank select and address. A downstream DRAM timing engine consumes them at its own pace. The sequencer holds each word until it is accepted. When the last pause of the last chip has run out, it pulses `done` for one cycle so that the memory controller can enter normal operation.

Top module: `ddr2_init_seq`

## Requirements
- R1: After reset `cmd_valid`, `busy` and `done` are all 0.
- R2: A start with a chip count from 1 to 4 sets up chips 0, 1, ... in ascending order, and `cmd_chip` carries the chip index. Count values 5 to 7 are treated as 4.
- R3: The per-chip order is: NOP, precharge-all, pause, write bank 2, write bank 3, write bank 1, write bank 0, precharge-all, auto-refresh, auto-refresh, write bank 0, pause, write bank 1, pause, write bank 1, pause. `cmd_kind` encodes precharge-all as 0, auto-refresh as 1, mode-register write as 2 and NOP as 3. `cmd_bank` selects the register written (0 main, 1 extended, 2 and 3 the further extended registers) and is 0 for every other kind.
- R4: The first bank-0 write carries the base mode word with bit 8 (DLL reset) set. The second carries it with bit 8 cleared.
- R5: The bank-2 and bank-3 writes carry address 0. The first bank-1 write carries the base extended word with bits 9:7 cleared. The calibration-entry write sets bits 9:7 to 7 and bit 14 to 1. The calibration-exit write sets bits 9:7 to 0 and bit 14 to 1. All other address bits come from the base extended word.
- R6: After the command before a pause is accepted, `cmd_valid` stays low for exactly max(`wait_len`,1) cycles. After any other accepted command, the next command is valid in the following cycle.
- R7: While `cmd_valid` is high and `cmd_ready` is low, `cmd_valid` and the whole command word hold their values.
- R8: `done` is a one-cycle pulse. It rises max(`wait_len`,1) cycles after the last calibration-exit write is accepted, and `busy` is low while it is high.
- R9: A start with chip count 0 raises `done` in the next cycle and issues no command.
- R10: While `busy` is high, `start` and changes to the configuration inputs have no effect on the command stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin the sequence (taken only when idle) |
| chip_count | input | CHIP_W+1 | Number of chips to set up |
| mr_base | input | ADDR_W | Base main mode-register word |
| emr_base | input | ADDR_W | Base extended mode-register word |
| wait_len | input | WAIT_W | Pause length in cycles (0 acts as 1) |
| cmd_valid | output | 1 | Command word valid |
| cmd_ready | input | 1 | Command word accepted when high with valid |
| cmd_chip | output | CHIP_W | Chip select of the command |
| cmd_kind | output | 2 | Command kind |
| cmd_bank | output | 2 | Bank / register select |
| cmd_addr | output | ADDR_W | Address bits |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
Two events can land on the same edge: a new `start` pulse and the acceptance of a command in mid-sequence. The bench raises `start` with altered configuration inputs on the exact cycle the first auto-refresh of chip 0 is presented. Under the free-running ready pattern, that is also a cycle in which the command is taken. The run is judged by checking that every later command word, every pause length and the final `done` timing still match the values computed from the configuration latched at the original start. A second pairing, a ready stall against a word that must hold, is provoked by three ready patterns that hold each command for a varying number of cycles.

// File: rtl/ddr2_init_pkg.sv
package ddr2_init_pkg;

  typedef enum logic [1:0] {
    CMD_PREA = 2'd0,
    CMD_REF  = 2'd1,
    CMD_MRS  = 2'd2,
    CMD_NOP  = 2'd3
  } cmd_kind_e;

  localparam int STEP_W    = 4;
  localparam int LAST_STEP = 15;

  localparam int DLL_BIT   = 8;
  localparam int OCD_LSB   = 7;
  localparam int MSEL_BIT  = 14;
  localparam logic [2:0] OCD_ENTER = 3'd7;
  localparam logic [2:0] OCD_EXIT  = 3'd0;
  localparam logic [2:0] OCD_ALL   = 3'd7;

  localparam logic [1:0] SEL_MR   = 2'd0;
  localparam logic [1:0] SEL_EMR  = 2'd1;
  localparam logic [1:0] SEL_EMR2 = 2'd2;
  localparam logic [1:0] SEL_EMR3 = 2'd3;

endpackage

// File: rtl/ddr2_init_step_dec.sv
module ddr2_init_step_dec
  import ddr2_init_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic [STEP_W-1:0] step,
  input  logic [ADDR_W-1:0] mr_val,
  input  logic [ADDR_W-1:0] emr_val,
  output logic              is_wait,
  output cmd_kind_e         kind,
  output logic [1:0]        bank,
  output logic [ADDR_W-1:0] addr
);

  localparam logic [ADDR_W-1:0] DLL_MASK  = ADDR_W'(1) << DLL_BIT;
  localparam logic [ADDR_W-1:0] OCD_MASK  = ADDR_W'(OCD_ALL) << OCD_LSB;
  localparam logic [ADDR_W-1:0] MSEL_MASK = ADDR_W'(1) << MSEL_BIT;
  localparam logic [ADDR_W-1:0] OCD_IN    = ADDR_W'(OCD_ENTER) << OCD_LSB;
  localparam logic [ADDR_W-1:0] OCD_OUT   = ADDR_W'(OCD_EXIT) << OCD_LSB;

  logic [ADDR_W-1:0] emr_clr;
  assign emr_clr = emr_val & ~OCD_MASK;

  always_comb begin
    is_wait = 1'b0;
    kind    = CMD_PREA;
    bank    = 2'd0;
    addr    = '0;
    case (step)
      4'd0:  kind = CMD_NOP;
      4'd1:  kind = CMD_PREA;
      4'd3:  begin kind = CMD_MRS; bank = SEL_EMR2; end
      4'd4:  begin kind = CMD_MRS; bank = SEL_EMR3; end
      4'd5:  begin kind = CMD_MRS; bank = SEL_EMR; addr = emr_clr; end
      4'd6:  begin kind = CMD_MRS; bank = SEL_MR;  addr = mr_val | DLL_MASK; end
      4'd7:  kind = CMD_PREA;
      4'd8:  kind = CMD_REF;
      4'd9:  kind = CMD_REF;
      4'd10: begin kind = CMD_MRS; bank = SEL_MR;  addr = mr_val & ~DLL_MASK; end
      4'd12: begin kind = CMD_MRS; bank = SEL_EMR; addr = emr_clr | OCD_IN | MSEL_MASK; end
      4'd14: begin kind = CMD_MRS; bank = SEL_EMR; addr = emr_clr | OCD_OUT | MSEL_MASK; end
      default: is_wait = 1'b1;
    endcase
  end

endmodule

// File: rtl/ddr2_init_wait.sv
module ddr2_init_wait #(
  parameter int WAIT_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [WAIT_W-1:0] len,
  output logic              expire
);

  logic [WAIT_W-1:0] cnt_q;
  logic [WAIT_W-1:0] len_eff;

  assign len_eff = (len == '0) ? WAIT_W'(1) : len;
  assign expire  = (cnt_q == WAIT_W'(1));

  always_ff @(posedge clk) begin
    if (rst)                cnt_q <= '0;
    else if (load)          cnt_q <= len_eff;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  // R6: a pause is only started when the previous one has fully run out
  a_r6_load_idle: assert property (@(posedge clk) disable iff (rst)
    load |-> cnt_q == '0);
  // R6: every started pause lasts at least one cycle
  a_r6_len_min: assert property (@(posedge clk) disable iff (rst)
    load |=> cnt_q != '0);

endmodule

// File: rtl/ddr2_init_seq.sv
module ddr2_init_seq
  import ddr2_init_pkg::*;
#(
  parameter int CHIP_W = 2,
  parameter int ADDR_W = 16,
  parameter int WAIT_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [CHIP_W:0]   chip_count,
  input  logic [ADDR_W-1:0] mr_base,
  input  logic [ADDR_W-1:0] emr_base,
  input  logic [WAIT_W-1:0] wait_len,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output logic [CHIP_W-1:0] cmd_chip,
  output logic [1:0]        cmd_kind,
  output logic [1:0]        cmd_bank,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic              busy,
  output logic              done
);

  localparam int CNT_W     = CHIP_W + 1;
  localparam int MAX_CHIPS = 1 << CHIP_W;

  // latched configuration
  logic [CNT_W-1:0]  cnt_q;
  logic [ADDR_W-1:0] mr_q, emr_q;
  logic [WAIT_W-1:0] wait_q;

  // walk state
  logic              busy_q, done_q;
  logic [STEP_W-1:0] step_q;
  logic [CNT_W-1:0]  chip_q;

  // registered command word
  logic              valid_q;
  cmd_kind_e         kind_q;
  logic [1:0]        bank_q;
  logic [ADDR_W-1:0] addr_q;

  logic [CNT_W-1:0]  cnt_clamp;
  logic              go, go_run, go_zero;
  logic              accept, expire, adv, last_step, finish;
  logic [STEP_W-1:0] nxt_step, dec_step;
  logic [CNT_W-1:0]  chip_inc, nxt_chip;
  logic              dec_wait;
  cmd_kind_e         dec_kind;
  logic [1:0]        dec_bank;
  logic [ADDR_W-1:0] dec_addr;
  logic              tmr_load;

  assign cnt_clamp = (chip_count > CNT_W'(MAX_CHIPS)) ? CNT_W'(MAX_CHIPS) : chip_count;
  assign go        = start && !busy_q;
  assign go_run    = go && (cnt_clamp != '0);
  assign go_zero   = go && (cnt_clamp == '0);

  assign accept    = valid_q && cmd_ready;
  assign adv       = busy_q && (accept || expire);
  assign last_step = (step_q == STEP_W'(LAST_STEP));
  assign nxt_step  = step_q + 1'b1;
  assign chip_inc  = chip_q + 1'b1;
  assign nxt_chip  = last_step ? chip_inc : chip_q;
  assign finish    = adv && last_step && (chip_inc == cnt_q);
  assign dec_step  = go_run ? '0 : nxt_step;
  assign tmr_load  = adv && !finish && dec_wait;

  ddr2_init_step_dec #(.ADDR_W(ADDR_W)) dec_i (
    .step    (dec_step),
    .mr_val  (mr_q),
    .emr_val (emr_q),
    .is_wait (dec_wait),
    .kind    (dec_kind),
    .bank    (dec_bank),
    .addr    (dec_addr)
  );

  ddr2_init_wait #(.WAIT_W(WAIT_W)) wait_i (
    .clk    (clk),
    .rst    (rst),
    .load   (tmr_load),
    .len    (wait_q),
    .expire (expire)
  );

  // configuration capture: only when a start is taken
  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      mr_q   <= '0;
      emr_q  <= '0;
      wait_q <= '0;
    end else if (go) begin
      cnt_q  <= cnt_clamp;
      mr_q   <= mr_base;
      emr_q  <= emr_base;
      wait_q <= wait_len;
    end
  end

  // walk control and command register
  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      step_q  <= '0;
      chip_q  <= '0;
      valid_q <= 1'b0;
      kind_q  <= CMD_PREA;
      bank_q  <= '0;
      addr_q  <= '0;
    end else begin
      done_q <= 1'b0;
      if (go_zero) begin
        done_q <= 1'b1;
      end else if (go_run) begin
        busy_q  <= 1'b1;
        step_q  <= '0;
        chip_q  <= '0;
        valid_q <= 1'b1;
        kind_q  <= dec_kind;
        bank_q  <= dec_bank;
        addr_q  <= dec_addr;
      end else if (finish) begin
        busy_q  <= 1'b0;
        done_q  <= 1'b1;
        valid_q <= 1'b0;
      end else if (adv) begin
        step_q  <= nxt_step;
        chip_q  <= nxt_chip;
        valid_q <= !dec_wait;
        if (!dec_wait) begin
          kind_q <= dec_kind;
          bank_q <= dec_bank;
          addr_q <= dec_addr;
        end
      end
    end
  end

  assign cmd_valid = valid_q;
  assign cmd_chip  = chip_q[CHIP_W-1:0];
  assign cmd_kind  = kind_q;
  assign cmd_bank  = bank_q;
  assign cmd_addr  = addr_q;
  assign busy      = busy_q;
  assign done      = done_q;

  // R1: nothing is presented while idle
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !busy_q |-> !valid_q);
  // R2: commands only address chips below the latched count
  a_r2_chip_range: assert property (@(posedge clk) disable iff (rst)
    valid_q |-> chip_q < cnt_q);
  // R7: a stalled word holds
  a_r7_hold: assert property (@(posedge clk) disable iff (rst)
    (valid_q && !cmd_ready) |=> (valid_q && $stable(kind_q) && $stable(bank_q)
                                 && $stable(addr_q) && $stable(chip_q)));
  // R8: done is a single-cycle pulse, raised only while idle
  a_r8_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done_q |=> !done_q);
  a_r8_done_idle: assert property (@(posedge clk) disable iff (rst)
    done_q |-> (!busy_q && !valid_q));
  // R9: a zero count finishes at once with no command
  a_r9_zero_count: assert property (@(posedge clk) disable iff (rst)
    (start && !busy_q && chip_count == '0) |=> (done_q && !valid_q));
  // R10: a start while busy does not restart the walk
  a_r10_no_restart: assert property (@(posedge clk) disable iff (rst)
    (start && busy_q && !finish && !adv) |=> ($stable(step_q) && $stable(chip_q)));

endmodule

// File: tb/ddr2_init_seq_tb.sv
module ddr2_init_seq_tb_top;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic        start;
  logic [2:0]  chip_count;
  logic [15:0] mr_base, emr_base;
  logic [7:0]  wait_len;
  logic        cmd_valid, cmd_ready;
  logic [1:0]  cmd_chip, cmd_kind, cmd_bank;
  logic [15:0] cmd_addr;
  logic        busy, done;

  int vectors = 0;
  int miscompares = 0;
  int cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ddr2_init_seq dut_i (
    .clk(clk), .rst(rst), .start(start), .chip_count(chip_count),
    .mr_base(mr_base), .emr_base(emr_base), .wait_len(wait_len),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_chip(cmd_chip),
    .cmd_kind(cmd_kind), .cmd_bank(cmd_bank), .cmd_addr(cmd_addr),
    .busy(busy), .done(done)
  );

  // fields: [44:42] count, [41:26] mr, [25:10] emr, [9:2] wait, [1:0] ready mode
  localparam logic [44:0] VEC [5] = '{
    {3'd1, 16'h0452, 16'h0044, 8'd0, 2'd0},
    {3'd2, 16'h0863, 16'h0002, 8'd3, 2'd1},
    {3'd4, 16'h0542, 16'h4384, 8'd5, 2'd2},
    {3'd7, 16'h0A53, 16'h0040, 8'd1, 2'd0},
    {3'd3, 16'h0652, 16'h0006, 8'd2, 2'd1}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // expected word {kind, bank, addr}, derived from the requirement text
  function automatic logic [19:0] exp_cmd(input int s, input logic [15:0] mr, input logic [15:0] emr);
    logic [15:0] ec;
    ec = emr & 16'hFC7F;
    case (s)
      0:       return {2'd3, 2'd0, 16'h0000};
      3:       return {2'd2, 2'd2, 16'h0000};
      4:       return {2'd2, 2'd3, 16'h0000};
      5:       return {2'd2, 2'd1, ec};
      6:       return {2'd2, 2'd0, mr | 16'h0100};
      8, 9:    return {2'd1, 2'd0, 16'h0000};
      10:      return {2'd2, 2'd0, mr & 16'hFEFF};
      12:      return {2'd2, 2'd1, ec | 16'h4380};
      14:      return {2'd2, 2'd1, ec | 16'h4000};
      default: return {2'd0, 2'd0, 16'h0000};
    endcase
  endfunction

  function automatic logic rdy_pat(input logic [1:0] mode);
    case (mode)
      2'd0:    return 1'b1;
      2'd1:    return (cyc % 3) != 0;
      default: return (cyc % 5) == 4;
    endcase
  endfunction

  task automatic run_case(input logic [2:0] cnt, input logic [15:0] mr, input logic [15:0] emr,
                          input logic [7:0] wl, input logic [1:0] mode);
    int nch, nw, gap;
    logic prev_wait, seen;
    logic [19:0] e;
    string atag;
    nch = (cnt > 3'd4) ? 4 : int'(cnt);
    nw  = (wl == 8'd0) ? 1 : int'(wl);
    @(negedge clk);
    cyc++;
    chip_count = cnt; mr_base = mr; emr_base = emr; wait_len = wl;
    start = 1'b1; cmd_ready = 1'b0;
    prev_wait = 1'b0;
    for (int c = 0; c < nch; c++) begin
      for (int s = 0; s < 16; s++) begin
        if (s == 2 || s == 11 || s == 13 || s == 15) begin
          prev_wait = 1'b1;
          continue;
        end
        e = exp_cmd(s, mr, emr);
        atag = (s == 6 || s == 10) ? "R4" : ((s == 3 || s == 4 || s == 5 || s == 12 || s == 14) ? "R5" : "R3");
        gap = 0; seen = 1'b0;
        forever begin
          @(negedge clk);
          cyc++;
          // R10: retrigger with altered configuration while busy
          start = (c == 0 && s == 8);
          chip_count = 3'd1; mr_base = 16'hFFFF; emr_base = 16'hFFFF; wait_len = 8'd0;
          cmd_ready = rdy_pat(mode);
          #1;
          if (!cmd_valid) begin
            if (seen) chk("R7 valid dropped", 0, 1);
            gap++;
            if (gap > 400) break;
          end else begin
            if (!seen) begin
              chk("R6 gap", gap, prev_wait ? nw : 0);
              chk("R2 chip", cmd_chip, c);
              chk("R3 kind", cmd_kind, e[19:18]);
              chk("R3 bank", cmd_bank, e[17:16]);
              chk(atag, cmd_addr, e[15:0]);
              chk("R10 busy", busy, 1);
            end else begin
              chk("R7 hold", {cmd_chip, cmd_kind, cmd_bank, cmd_addr}, {c[1:0], e});
            end
            seen = 1'b1;
            if (cmd_ready) break;
          end
        end
        prev_wait = 1'b0;
      end
    end
    start = 1'b0;
    gap = 0;
    forever begin
      @(negedge clk);
      cyc++;
      cmd_ready = rdy_pat(mode);
      #1;
      if (done || gap > 400) break;
      if (cmd_valid) chk("R2 extra command", 1, 0);
      gap++;
    end
    chk("R8 done delay", gap, nw);
    chk("R8 busy at done", busy, 0);
    chk("R8 valid at done", cmd_valid, 0);
    @(negedge clk);
    cyc++;
    #1;
    chk("R8 done pulse width", done, 0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    miscompares++;
    vectors++;
    $display("FAIL watchdog actual=expired expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin : main
    rst = 1'b1; start = 1'b0; cmd_ready = 1'b0;
    chip_count = '0; mr_base = '0; emr_base = '0; wait_len = '0;
    repeat (3) @(negedge clk);
    #1;
    chk("R1 valid", cmd_valid, 0);
    chk("R1 busy", busy, 0);
    chk("R1 done", done, 0);
    @(negedge clk);
    rst = 1'b0;

    for (int v = 0; v < 5; v++) begin
      run_case(VEC[v][44:42], VEC[v][41:26], VEC[v][25:10], VEC[v][9:2], VEC[v][1:0]);
      repeat (2) @(negedge clk);
    end

    // R9: zero chip count
    @(negedge clk);
    chip_count = 3'd0; start = 1'b1; cmd_ready = 1'b1;
    @(negedge clk);
    start = 1'b0;
    #1;
    chk("R9 done", done, 1);
    chk("R9 valid", cmd_valid, 0);
    chk("R9 busy", busy, 0);
    @(negedge clk);
    #1;
    chk("R9 done pulse", done, 0);
    chk("R9 no command", cmd_valid, 0);

    // R1: reset in mid-sequence returns outputs to idle
    @(negedge clk);
    chip_count = 3'd2; wait_len = 8'd4; start = 1'b1; cmd_ready = 1'b0;
    @(negedge clk);
    start = 1'b0;
    rst = 1'b1;
    @(negedge clk);
    #1;
    chk("R1 valid after reset", cmd_valid, 0);
    chk("R1 busy after reset", busy, 0);
    rst = 1'b0;

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule